// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block sits between three GPIO controllers and a platform interrupt controller that has fewer inputs than the controllers have interrupt lines. It takes 70 level interrupt inputs: 14 from controller 0, 24 from controller 1 and 32 from controller 2. It presents them on 41 outputs. There are 38 exclusive ("direct") outputs and three shared outputs, one for each controller. A shared output carries the OR of every input of its controller that currently has no direct output.

A single 32-bit routing register sets the routing. Each bit of the register decides which of two controllers owns one direct output. Bits 0 to 13 pair controller 0 line i with controller 2 line i. Bits 14 to 31 pair controller 1 line i-14 with controller 2 line i. For either pair, a 1 gives the direct output to controller 2 and a 0 gives it to controller 0 or 1. The input that loses the pair is folded into its own controller's shared line. Controller 1 lines 18 to 23 are never paired, so they always own direct outputs 32 to 37.

The interrupt path is purely combinational. It has no masking, edge detection or acknowledge, because those belong to the downstream controller. The register port is a plain write strobe with write data and a continuous read-back. None of the interrupt signals is a data stream, so the block has no valid/ready interface and no back-pressure.

Top module: `gpio_irq_router`

## Requirements
- R1: After an active-low reset the routing register holds 0x00000000. `cfg_rdata` then reads 0, controller 0 lines and controller 1 lines 0 to 17 own their direct outputs, and controller 2 drives only shared output 2.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next rising clock edge. Before that edge, `cfg_rdata` still shows the old value. After it, `cfg_rdata` shows the stored value. With `cfg_we` low, the register does not change.
- R3: For bit i in 0..13, `direct_irq[i]` equals `src2_irq[i]` when the bit is 1, and equals `src0_irq[i]` when the bit is 0.
- R4: For bit i in 14..31, `direct_irq[i]` equals `src2_irq[i]` when the bit is 1, and equals `src1_irq[i-14]` when the bit is 0.
- R5: `direct_irq[37:32]` equals `src1_irq[23:18]` in the same order for every register value.
- R6: `shared_irq[0]` is the OR of `src0_irq[i] & bit i` over i in 0..13.
- R7: `shared_irq[1]` is the OR of `src1_irq[j] & bit (j+14)` over j in 0..17. Lines 18 to 23 never reach it.
- R8: `shared_irq[2]` is the OR of `src2_irq[i] & ~bit i` over i in 0..31.
- R9: Inputs reach the outputs without a clock edge and without any masking. A change in an input between edges is visible on the outputs before the next edge.
- R10: For any register value, an asserted single input raises exactly one output. That output is either a direct line or the shared line of the input's own controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the routing register |
| cfg_wdata | input | 32 | Routing value to store |
| cfg_rdata | output | 32 | Stored routing value |
| src0_irq | input | 14 | Controller 0 interrupt lines |
| src1_irq | input | 24 | Controller 1 interrupt lines |
| src2_irq | input | 32 | Controller 2 interrupt lines |
| direct_irq | output | 38 | Exclusive interrupt outputs |
| shared_irq | output | 3 | Shared outputs for controllers 0, 1, 2 |

## Verification
The table drives all-ones patterns on one controller at a time under routing values of zero and all-ones. This shows whether each shared line picks up the correct controller and polarity, and whether the fixed controller 1 lines stay in place. Alternating and random routing values combined with alternating and random inputs separate the lower pairs (controller 0) from the upper pairs (controller 1), and catch off-by-one line offsets. A walking single-input sweep under random routing shows an input that is dropped or duplicated. A mid-cycle input change separates a combinational path from a registered one. Writes with the strobe low and reads taken just before the write edge separate correct register timing from early or unguarded updates.

// File: rtl/gpio_irq_route_pkg.sv
package gpio_irq_route_pkg;
  localparam int unsigned GRP0_LINES = 14;
  localparam int unsigned GRP1_LINES = 24;
  localparam int unsigned GRP2_LINES = 32;
  localparam int unsigned SHARED_OUTS = 3;
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= wdata;
  end

  assign q = q_r;

  // R2: a strobed write is visible one edge later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));

  // R2: without a strobe the stored value holds
  a_r2_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int unsigned G0 = 14,
  parameter int unsigned G1 = 24,
  parameter int unsigned G2 = 32,
  localparam int unsigned G1M = G2 - G0,
  localparam int unsigned G1F = G1 - G1M,
  localparam int unsigned ND  = G2 + G1F
) (
  input  logic [G2-1:0]  sel,
  input  logic [G0-1:0]  s0,
  input  logic [G1-1:0]  s1,
  input  logic [G2-1:0]  s2,
  output logic [ND-1:0]  direct,
  output logic [G0-1:0]  nd0,
  output logic [G1M-1:0] nd1,
  output logic [G2-1:0]  nd2
);
  // Lower pairs: controller 0 against controller 2
  for (genvar i = 0; i < G0; i++) begin : g_lo_pair
    assign direct[i] = sel[i] ? s2[i] : s0[i];
    assign nd0[i]    = sel[i] & s0[i];
    assign nd2[i]    = ~sel[i] & s2[i];
  end

  // Upper pairs: controller 1 against controller 2
  for (genvar i = G0; i < G2; i++) begin : g_hi_pair
    assign direct[i]  = sel[i] ? s2[i] : s1[i-G0];
    assign nd1[i-G0]  = sel[i] & s1[i-G0];
    assign nd2[i]     = ~sel[i] & s2[i];
  end

  // Unpaired controller 1 lines keep their own outputs
  for (genvar k = 0; k < G1F; k++) begin : g_fixed
    assign direct[G2+k] = s1[G1M+k];
  end
endmodule

// File: rtl/irq_route_share.sv
module irq_route_share #(
  parameter int unsigned N = 14
) (
  input  logic [N-1:0] pend,
  output logic         any
);
  assign any = |pend;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_route_pkg::*;
#(
  parameter int unsigned G0 = GRP0_LINES,
  parameter int unsigned G1 = GRP1_LINES,
  parameter int unsigned G2 = GRP2_LINES,
  localparam int unsigned G1M = G2 - G0,
  localparam int unsigned G1F = G1 - G1M,
  localparam int unsigned ND  = G2 + G1F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [G2-1:0]          cfg_wdata,
  output logic [G2-1:0]          cfg_rdata,
  input  logic [G0-1:0]          src0_irq,
  input  logic [G1-1:0]          src1_irq,
  input  logic [G2-1:0]          src2_irq,
  output logic [ND-1:0]          direct_irq,
  output logic [SHARED_OUTS-1:0] shared_irq
);
  logic [G2-1:0]  route_q;
  logic [G0-1:0]  nd0;
  logic [G1M-1:0] nd1;
  logic [G2-1:0]  nd2;

  irq_route_cfg #(.W(G2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(route_q)
  );

  assign cfg_rdata = route_q;

  irq_route_xbar #(.G0(G0), .G1(G1), .G2(G2)) u_xbar (
    .sel(route_q), .s0(src0_irq), .s1(src1_irq), .s2(src2_irq),
    .direct(direct_irq), .nd0(nd0), .nd1(nd1), .nd2(nd2)
  );

  irq_route_share #(.N(G0))  u_sh0 (.pend(nd0), .any(shared_irq[0]));
  irq_route_share #(.N(G1M)) u_sh1 (.pend(nd1), .any(shared_irq[1]));
  irq_route_share #(.N(G2))  u_sh2 (.pend(nd2), .any(shared_irq[2]));

  // R5: unpaired controller 1 lines always land on the top direct outputs
  a_r5_fixed_lines: assert property (@(posedge clk) disable iff (!rst_n)
    direct_irq[ND-1 -: G1F] == src1_irq[G1-1 -: G1F]);

  // R6: no lower bit set means controller 0 has no shared traffic
  a_r6_shared0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[G0-1:0] == '0) |-> !shared_irq[0]);

  // R7: no upper bit set means controller 1 has no shared traffic
  a_r7_shared1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[G2-1:G0] == '0) |-> !shared_irq[1]);

  // R8: all bits set means every controller 2 line is direct
  a_r8_shared2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&cfg_rdata) |-> !shared_irq[2]);

  // R10: no input asserted, no output asserted
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ({src0_irq, src1_irq, src2_irq} == '0) |-> ({direct_irq, shared_irq} == '0));
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb_top;
  localparam int unsigned G0 = 14, G1 = 24, G2 = 32, ND = 38;
  localparam int unsigned NV = 8;
  // {route, src2, src1, src0}
  localparam logic [101:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 24'h00_0000, 14'h3FFF},
    {32'h0000_0000, 32'hFFFF_FFFF, 24'h00_0000, 14'h0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 24'h00_0000, 14'h3FFF},
    {32'hFFFF_FFFF, 32'h0000_0000, 24'hFF_FFFF, 14'h0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 24'h00_0000, 14'h0000},
    {32'hAAAA_AAAA, 32'h5555_5555, 24'hAA_AAAA, 14'h2AAA},
    {32'h5555_5555, 32'hFFFF_FFFF, 24'h03_FFFF, 14'h3FFF},
    {32'h0000_C001, 32'h8000_4000, 24'h00_0003, 14'h2001}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [G2-1:0] cfg_wdata = '0, cfg_rdata;
  logic [G0-1:0] src0 = '0;
  logic [G1-1:0] src1 = '0;
  logic [G2-1:0] src2 = '0;
  logic [ND-1:0] direct;
  logic [2:0]    shared;
  int unsigned n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src0_irq(src0), .src1_irq(src1), .src2_irq(src2),
    .direct_irq(direct), .shared_irq(shared)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [G2-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic check_routing(input logic [G2-1:0] r);
    logic [ND-1:0] ed;
    logic [2:0]    es;
    es = '0;
    for (int i = 0; i < G0; i++) begin
      ed[i] = r[i] ? src2[i] : src0[i];
      es[0] |= r[i] & src0[i];
    end
    for (int i = G0; i < G2; i++) begin
      ed[i] = r[i] ? src2[i] : src1[i-G0];
      es[1] |= r[i] & src1[i-G0];
    end
    for (int i = 0; i < G2; i++) es[2] |= ~r[i] & src2[i];
    for (int k = 0; k < 6; k++) ed[G2+k] = src1[18+k];
    check("R3 direct low pairs", 64'(direct[13:0]), 64'(ed[13:0]));
    check("R4 direct high pairs", 64'(direct[31:14]), 64'(ed[31:14]));
    check("R5 fixed lines", 64'(direct[37:32]), 64'(ed[37:32]));
    check("R6 shared0", 64'(shared[0]), 64'(es[0]));
    check("R7 shared1", 64'(shared[1]), 64'(es[1]));
    check("R8 shared2", 64'(shared[2]), 64'(es[2]));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value and default routing
    check("R1 reset readback", 64'(cfg_rdata), 64'h0);
    src2 = '1; #1;
    check("R1 ctrl2 to shared", 64'({direct, shared}), 64'({38'h0, 3'b100}));
    src2 = '0;

    // R2: write timing, then an unstrobed write value
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'hA5A5_5A5A; #1;
    check("R2 old value before edge", 64'(cfg_rdata), 64'h0);
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = 32'h1234_5678; #1;
    check("R2 stored after edge", 64'(cfg_rdata), 64'hA5A5_5A5A);
    @(negedge clk); @(negedge clk); #1;
    check("R2 no strobe no change", 64'(cfg_rdata), 64'hA5A5_5A5A);

    // Table walk: R3..R8
    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][101:70]);
      src2 = VEC[v][69:38]; src1 = VEC[v][37:14]; src0 = VEC[v][13:0];
      #1; check_routing(VEC[v][101:70]);
    end

    // Random routing and inputs
    for (int n = 0; n < 40; n++) begin
      logic [G2-1:0] r;
      r = $urandom;
      write_cfg(r);
      src0 = 14'($urandom); src1 = 24'($urandom); src2 = $urandom;
      #1; check_routing(r);
    end

    // R9: change inputs mid-cycle, observe before the next edge
    write_cfg(32'h0000_0000);
    src0 = '0; src1 = '0; src2 = '0;
    @(posedge clk); #2;
    src0[5] = 1'b1; #1;
    check("R9 comb path ctrl0", 64'(direct), 64'(38'(1) << 5));
    src0[5] = 1'b0; src1[20] = 1'b1; #1;
    check("R9 comb path fixed", 64'(direct), 64'(38'(1) << 34));
    src1 = '0;

    // R10: walking single input under random routing
    for (int n = 0; n < 8; n++) begin
      logic [G2-1:0] r;
      r = (n == 0) ? 32'h0 : (n == 1) ? 32'hFFFF_FFFF : $urandom;
      write_cfg(r);
      for (int j = 0; j < G0 + G1 + G2; j++) begin
        logic [69:0] all;
        all = 70'(1) << j;
        {src2, src1, src0} = all; #1;
        check("R10 exactly one output", 64'($countones({direct, shared})), 64'd1);
      end
    end
    {src2, src1, src0} = '0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule